// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block drives one fully pipelined vector functional unit through the elements of a single vector operation. It accepts a command when it is idle. It then reads one operand element per clock, indexed from 0 up to the vector length minus one. The operands come from a register file outside the block, which answers each read index in the same cycle. Each element passes through a pipeline whose depth depends on the operation. The result leaves the block together with its element index and a write enable.

Four arithmetic forms are supported: vector plus vector, scalar plus vector, vector times vector and scalar times vector. In the scalar forms the scalar is captured at acceptance and used for every element. The block also has an element-wise equality compare that fills a per-element mask register, and a command that loads that register in one step from a mask-source word. When masking is enabled for an operation, elements whose mask bit is 0 still take their clock slot but raise no write.

Top module: `vseq_unit`

## Requirements
- R1: The result data is, truncated to DW bits: op 0 gives a+b, op 1 gives scalar+a, op 2 gives a*b, op 3 gives scalar*a. Here a and b are the elements read at that index, and scalar is the value captured when the command was accepted.
- R2: When a command is accepted in cycle s, `rd_valid` is high in cycles s+1 to s+VL, and `rd_idx` runs 0, 1, ..., VL-1 in those cycles.
- R3: The result slot for element i has `res_valid` high in cycle s+L+i, with `res_idx` = i. L is 6 for ops 0, 1 and 4, and 7 for ops 2 and 3.
- R4: With `mask_en` set at acceptance, `res_we` is high in a slot only when bit `res_idx` of `mask_q` is 1. Masked slots still show `res_valid`. With `mask_en` clear, every arithmetic slot writes.
- R5: Op 4 (compare-equal) never raises `res_we`. In the cycle after slot i, bit i of `mask_q` holds (a==b) for that element. Bits at or above VL keep their value.
- R6: Op 5, accepted while idle, loads `mask_q` from `mask_src` in the next cycle. `busy` stays low and no slot occurs.
- R7: The effective length is min(`vlen`, 64). A command of ops 0 to 4 with effective length 0 is not accepted. Ops 6 and 7 are never accepted.
- R8: `busy` is high from cycle s+1 to cycle s+L+VL-1, both included. A `start` seen while `busy` is high is ignored, including in the final slot cycle.
- R9: During reset, `busy`, `rd_valid`, `res_valid` and `res_we` are 0, and `mask_q` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request |
| op | input | 3 | Operation code (0..5) |
| vlen | input | 7 | Requested vector length |
| mask_en | input | 1 | Apply mask to writes |
| scalar | input | DW | Scalar operand |
| mask_src | input | MVL | Value for mask load |
| a_elem | input | DW | First operand element at `rd_idx` |
| b_elem | input | DW | Second operand element at `rd_idx` |
| rd_valid | output | 1 | Operand read in this cycle |
| rd_idx | output | 6 | Operand element index |
| busy | output | 1 | Operation in flight |
| res_valid | output | 1 | Result slot |
| res_idx | output | 6 | Element index of the slot |
| res_data | output | DW | Result element |
| res_we | output | 1 | Write enable for the result |
| mask_q | output | MVL | Mask register |

## Verification
The final result slot of one operation and a new command request can fall in the same cycle. The bench drives `start` exactly in the last slot cycle, with a mask-load command, and holds it for one more cycle. The reference model must see the request ignored while `busy` is high and accepted one cycle later, and `mask_q` must change only after that. A second case is a compare that writes mask bits while the mask is also in use. This is judged by comparing the per-cycle mask against a behavioural model that updates bit i one cycle after slot i.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam logic [2:0] OP_VADD    = 3'd0;
  localparam logic [2:0] OP_SADD    = 3'd1;
  localparam logic [2:0] OP_VMUL    = 3'd2;
  localparam logic [2:0] OP_SMUL    = 3'd3;
  localparam logic [2:0] OP_CMPEQ   = 3'd4;
  localparam logic [2:0] OP_SETMASK = 3'd5;

  function automatic logic is_mul(input logic [2:0] o);
    return (o == OP_VMUL) || (o == OP_SMUL);
  endfunction

  function automatic logic is_scalar(input logic [2:0] o);
    return (o == OP_SADD) || (o == OP_SMUL);
  endfunction

  function automatic logic is_arith(input logic [2:0] o);
    return o <= OP_SMUL;
  endfunction
endpackage

// File: rtl/vseq_issue.sv
module vseq_issue import vseq_pkg::*; #(
  parameter int DW      = 32,
  parameter int MVL     = 64,
  parameter int IW      = 6,
  parameter int VLW     = 7,
  parameter int LAT_ADD = 6,
  parameter int LAT_MUL = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [VLW-1:0] vlen,
  input  logic           mask_en,
  input  logic [DW-1:0]  scalar,
  output logic           busy,
  output logic           rd_valid,
  output logic [IW-1:0]  rd_idx,
  output logic [2:0]     op_q,
  output logic           men_q,
  output logic [DW-1:0]  sc_q,
  output logic           set_ok
);
  localparam int LMAX = (LAT_MUL > LAT_ADD) ? LAT_MUL : LAT_ADD;
  localparam int CW   = $clog2(LMAX + MVL + 1);

  logic [VLW-1:0] vl_eff;
  logic           run_ok;
  logic [CW-1:0]  lat_c;

  logic          busy_q, busy_d;
  logic          iss_q, iss_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          st_en;

  // R7: cap the length, refuse empty operations
  assign vl_eff = (vlen > VLW'(MVL)) ? VLW'(MVL) : vlen;
  assign run_ok = start && !busy_q && (op <= OP_CMPEQ) && (vl_eff != '0);
  assign set_ok = start && !busy_q && (op == OP_SETMASK);
  assign lat_c  = is_mul(op) ? CW'(LAT_MUL) : CW'(LAT_ADD);
  assign st_en  = run_ok || busy_q;

  always_comb begin
    busy_d = busy_q;
    iss_d  = iss_q;
    idx_d  = idx_q;
    cnt_d  = cnt_q;
    if (run_ok) begin
      busy_d = 1'b1;
      iss_d  = 1'b1;
      idx_d  = '0;
      cnt_d  = lat_c + CW'(vl_eff) - CW'(2);  // R8: busy through the last slot
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CW'(1);
      if (iss_q) begin
        if (idx_q == last_q) iss_d = 1'b0;
        else                 idx_d = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      iss_q  <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      iss_q  <= iss_d;
      idx_q  <= idx_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (run_ok) begin
      last_q <= IW'(vl_eff - VLW'(1));
      op_q   <= op;
      men_q  <= mask_en;
      sc_q   <= scalar;
    end
  end

  assign busy     = busy_q;
  assign rd_valid = iss_q;
  assign rd_idx   = idx_q;
endmodule

// File: rtl/vseq_pipe.sv
module vseq_pipe #(
  parameter int DW      = 32,
  parameter int IW      = 6,
  parameter int TAP_ADD = 4,
  parameter int TAP_MUL = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_mul,
  input  logic          in_valid,
  input  logic [IW-1:0] in_idx,
  input  logic [DW-1:0] in_data,
  input  logic          in_eq,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [DW-1:0] out_data,
  output logic          out_eq
);
  localparam int DEPTH = ((TAP_MUL > TAP_ADD) ? TAP_MUL : TAP_ADD) + 1;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic          nv, q_v;
    logic [IW-1:0] ni, q_i;
    logic [DW-1:0] nd, q_d;
    logic          ne, q_e;
    if (g == 0) begin : g_head
      assign nv = in_valid;
      assign ni = in_idx;
      assign nd = in_data;
      assign ne = in_eq;
    end else begin : g_tail
      assign nv = g_stage[g-1].q_v;
      assign ni = g_stage[g-1].q_i;
      assign nd = g_stage[g-1].q_d;
      assign ne = g_stage[g-1].q_e;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_v <= 1'b0;
      else        q_v <= nv;
    end
    always_ff @(posedge clk) begin
      if (nv) begin
        q_i <= ni;
        q_d <= nd;
        q_e <= ne;
      end
    end
  end

  // R3: the tap picks the per-operation latency
  assign out_valid = sel_mul ? g_stage[TAP_MUL].q_v : g_stage[TAP_ADD].q_v;
  assign out_idx   = sel_mul ? g_stage[TAP_MUL].q_i : g_stage[TAP_ADD].q_i;
  assign out_data  = sel_mul ? g_stage[TAP_MUL].q_d : g_stage[TAP_ADD].q_d;
  assign out_eq    = sel_mul ? g_stage[TAP_MUL].q_e : g_stage[TAP_ADD].q_e;
endmodule

// File: rtl/vseq_mask.sv
module vseq_mask #(
  parameter int MVL = 64,
  parameter int IW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [MVL-1:0] load_val,
  input  logic           bit_we,
  input  logic [IW-1:0]  bit_idx,
  input  logic           bit_val,
  output logic [MVL-1:0] mask_q
);
  logic [MVL-1:0] mask_r, mask_d;
  logic           en;

  assign en = load || bit_we;

  always_comb begin
    mask_d = mask_r;
    if (load)        mask_d = load_val;     // R6
    else if (bit_we) mask_d[bit_idx] = bit_val;  // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_r <= '1;  // R9
    else if (en) mask_r <= mask_d;
  end

  assign mask_q = mask_r;
endmodule

// File: rtl/vseq_unit.sv
module vseq_unit import vseq_pkg::*; #(
  parameter int DW      = 32,
  parameter int MVL     = 64,
  parameter int LAT_ADD = 6,
  parameter int LAT_MUL = 7,
  localparam int IW     = $clog2(MVL),
  localparam int VLW    = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [VLW-1:0] vlen,
  input  logic           mask_en,
  input  logic [DW-1:0]  scalar,
  input  logic [MVL-1:0] mask_src,
  input  logic [DW-1:0]  a_elem,
  input  logic [DW-1:0]  b_elem,
  output logic           rd_valid,
  output logic [IW-1:0]  rd_idx,
  output logic           busy,
  output logic           res_valid,
  output logic [IW-1:0]  res_idx,
  output logic [DW-1:0]  res_data,
  output logic           res_we,
  output logic [MVL-1:0] mask_q
);
  logic [2:0]    op_q;
  logic          men_q;
  logic [DW-1:0] sc_q;
  logic          set_ok;
  logic [DW-1:0] opnd, e_data;
  logic          e_eq;
  logic          p_valid, p_eq;
  logic [IW-1:0] p_idx;
  logic [DW-1:0] p_data;

  vseq_issue #(.DW(DW), .MVL(MVL), .IW(IW), .VLW(VLW),
               .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
    .mask_en(mask_en), .scalar(scalar), .busy(busy), .rd_valid(rd_valid),
    .rd_idx(rd_idx), .op_q(op_q), .men_q(men_q), .sc_q(sc_q), .set_ok(set_ok)
  );

  // R1: scalar forms broadcast the captured scalar
  assign opnd   = is_scalar(op_q) ? sc_q : b_elem;
  assign e_data = is_mul(op_q) ? (a_elem * opnd) : (a_elem + opnd);
  assign e_eq   = (a_elem == b_elem);

  vseq_pipe #(.DW(DW), .IW(IW), .TAP_ADD(LAT_ADD - 2), .TAP_MUL(LAT_MUL - 2)) u_pipe (
    .clk(clk), .rst_n(rst_n), .sel_mul(is_mul(op_q)), .in_valid(rd_valid),
    .in_idx(rd_idx), .in_data(e_data), .in_eq(e_eq), .out_valid(p_valid),
    .out_idx(p_idx), .out_data(p_data), .out_eq(p_eq)
  );

  assign res_valid = p_valid && busy;
  assign res_idx   = p_idx;
  assign res_data  = p_data;
  // R4: masked-off slots keep their destination untouched
  assign res_we    = res_valid && is_arith(op_q) && (!men_q || mask_q[p_idx]);

  vseq_mask #(.MVL(MVL), .IW(IW)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(set_ok), .load_val(mask_src),
    .bit_we(res_valid && (op_q == OP_CMPEQ)), .bit_idx(p_idx),
    .bit_val(p_eq), .mask_q(mask_q)
  );
endmodule

// File: rtl/vseq_unit_chk.sv
module vseq_unit_chk #(
  parameter int MVL = 64,
  localparam int IW = $clog2(MVL)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           rd_valid,
  input logic [IW-1:0]  rd_idx,
  input logic           res_valid,
  input logic [IW-1:0]  res_idx,
  input logic           res_we,
  input logic [MVL-1:0] mask_q,
  input logic [2:0]     op_q,
  input logic           men_q
);
  p_read_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_valid) |-> rd_idx == $past(rd_idx) + 1'b1);

  p_slot_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(res_valid) |-> res_idx == $past(res_idx) + 1'b1);

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && men_q && !mask_q[res_idx] |-> !res_we);

  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (op_q == 3'd4) |-> !res_we);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(res_valid && (op_q == 3'd4)) |=> $stable(mask_q));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !res_valid && !rd_valid && !res_we);
endmodule

bind vseq_unit vseq_unit_chk #(.MVL(MVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_valid(rd_valid), .rd_idx(rd_idx),
  .res_valid(res_valid), .res_idx(res_idx), .res_we(res_we), .mask_q(mask_q),
  .op_q(op_q), .men_q(men_q)
);

// File: tb/vseq_unit_bench.sv
module vseq_unit_bench;
  localparam int CLK_NS = 10;
  localparam int DW  = 32;
  localparam int MVL = 64;
  localparam int IW  = 6;

  logic clk, rst_n, start, mask_en;
  logic [2:0] op;
  logic [IW:0] vlen;
  logic [DW-1:0] scalar, a_elem, b_elem, res_data;
  logic [MVL-1:0] mask_src, mask_q;
  logic rd_valid, busy, res_valid, res_we;
  logic [IW-1:0] rd_idx, res_idx;

  logic [DW-1:0] A [MVL];
  logic [DW-1:0] B [MVL];

  assign a_elem = A[rd_idx];
  assign b_elem = B[rd_idx];

  vseq_unit #(.DW(DW), .MVL(MVL)) u_vseq_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
    .mask_en(mask_en), .scalar(scalar), .mask_src(mask_src), .a_elem(a_elem),
    .b_elem(b_elem), .rd_valid(rd_valid), .rd_idx(rd_idx), .busy(busy),
    .res_valid(res_valid), .res_idx(res_idx), .res_data(res_data),
    .res_we(res_we), .mask_q(mask_q)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, wd = 0;
  bit done = 0;
  int s_cyc = -1000, m_vl = 0;
  logic [2:0] m_op = 3'd0;
  bit m_men = 0;
  logic [DW-1:0] m_sc = '0;
  logic [MVL-1:0] m_mask = '1;

  function automatic int m_lat(input logic [2:0] o);
    return (o == 3'd2 || o == 3'd3) ? 7 : 6;
  endfunction

  function automatic bit m_busy(input int c);
    return (c >= s_cyc + 1) && (c <= s_cyc + m_lat(m_op) + m_vl - 1);
  endfunction

  function automatic logic [DW-1:0] m_res(input int i);
    logic [DW-1:0] b2;
    b2 = (m_op == 3'd1 || m_op == 3'd3) ? m_sc : B[i];
    return (m_op < 3'd2) ? A[i] + b2 : A[i] * b2;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference model state advance at each edge
  always @(posedge clk) begin
    if (rst_n) begin
      int i;
      i = cyc - s_cyc - m_lat(m_op);
      if (m_op == 3'd4 && i >= 0 && i < m_vl) m_mask[i] = (A[i] == B[i]);
      if (start && !m_busy(cyc)) begin
        int ve;
        ve = (vlen > MVL) ? MVL : int'(vlen);
        if (op == 3'd5) m_mask = mask_src;
        else if (op <= 3'd4 && ve != 0) begin
          s_cyc = cyc; m_vl = ve; m_op = op; m_men = mask_en; m_sc = scalar;
        end
      end
      cyc++;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit eb, er, es;
      int i;
      eb = m_busy(cyc);
      er = (cyc >= s_cyc + 1) && (cyc <= s_cyc + m_vl);
      i  = cyc - s_cyc - m_lat(m_op);
      es = (i >= 0) && (i < m_vl);
      chk(busy == eb, "R8 busy", 64'(busy), 64'(eb));
      chk(rd_valid == er, "R2 rd_valid", 64'(rd_valid), 64'(er));
      if (er) chk(rd_idx == IW'(cyc - s_cyc - 1), "R2 rd_idx", 64'(rd_idx), 64'(cyc - s_cyc - 1));
      chk(res_valid == es, "R3 res_valid", 64'(res_valid), 64'(es));
      if (es) begin
        bit ew;
        chk(res_idx == IW'(i), "R3 res_idx", 64'(res_idx), 64'(i));
        if (m_op < 3'd4) chk(res_data == m_res(i), "R1 res_data", 64'(res_data), 64'(m_res(i)));
        ew = (m_op < 3'd4) && (!m_men || m_mask[i]);
        chk(res_we == ew, (m_op == 3'd4) ? "R5 res_we" : "R4 res_we", 64'(res_we), 64'(ew));
      end else begin
        chk(res_we == 1'b0, "R4 res_we idle", 64'(res_we), 64'd0);
      end
      chk(mask_q == m_mask, "R5 R6 mask_q", mask_q, m_mask);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      errors++;
      $display("FAIL R8 watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic issue(input logic [2:0] o, input int vl, input bit men, input logic [DW-1:0] sc);
    @(negedge clk);
    op = o; vlen = (IW+1)'(vl); mask_en = men; scalar = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (m_busy(cyc) || busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int seed);
    for (int k = 0; k < MVL; k++) begin
      A[k] = DW'(k * 37 + seed);
      B[k] = DW'(k * 1009 + seed * 3 + 1);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; vlen = '0; mask_en = 1'b0;
    scalar = '0; mask_src = '0;
    fill(1);
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!busy && !rd_valid && !res_valid && !res_we, "R9 reset outputs", 64'({busy, rd_valid, res_valid, res_we}), 64'd0);
    chk(mask_q == '1, "R9 reset mask", mask_q, '1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    issue(3'd0, 8, 0, '0);            wait_idle;   // R1 R3 vector add
    fill(5);
    issue(3'd1, 5, 0, 32'h1000_0003); wait_idle;   // R1 scalar add
    for (int k = 0; k < MVL; k++) begin A[k] = 32'hFFFF_0000 + DW'(k); B[k] = 32'h0001_0003 * DW'(k + 1); end
    issue(3'd2, 10, 0, '0);           wait_idle;   // R1 R3 multiply, truncation
    issue(3'd3, 3, 0, 32'h0000_0101); wait_idle;   // R1 scalar multiply

    mask_src = 64'hAAAA_5555_F0F0_0F0F;
    issue(3'd5, 0, 0, '0);                          // R6 mask load
    @(negedge clk);
    chk(mask_q == 64'hAAAA_5555_F0F0_0F0F, "R6 mask load", mask_q, 64'hAAAA_5555_F0F0_0F0F);
    chk(busy == 1'b0, "R6 no busy", 64'(busy), 64'd0);

    fill(9);
    issue(3'd0, 16, 1, '0);           wait_idle;   // R4 masked add

    for (int k = 0; k < MVL; k++) begin A[k] = DW'(k); B[k] = (k % 3 == 0) ? DW'(k) : DW'(k + 1); end
    issue(3'd4, 12, 1, '0);           wait_idle;   // R5 compare into mask
    chk(mask_q[11:0] == 12'h249, "R5 compare bits", 64'(mask_q[11:0]), 64'h249);
    chk(mask_q[63:12] == 52'hAAAA_5555_F0F0_0, "R5 upper bits kept", 64'(mask_q[63:12]), 64'hAAAA_5555_F0F0_0);

    issue(3'd0, 0, 0, '0);                          // R7 empty length refused
    @(negedge clk);
    chk(busy == 1'b0, "R7 zero length", 64'(busy), 64'd0);
    fill(2);
    issue(3'd0, 100, 0, '0);          wait_idle;   // R7 length capped to 64
    issue(3'd6, 4, 0, '0);                          // R7 unused code refused
    @(negedge clk);
    chk(busy == 1'b0, "R7 unused op", 64'(busy), 64'd0);

    // R8: start while busy is ignored, also in the final slot cycle
    fill(4);
    issue(3'd0, 4, 0, '0);
    @(negedge clk);
    op = 3'd2; vlen = 7'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (cyc != s_cyc + 6 + m_vl - 1) @(negedge clk);
    op = 3'd5; mask_src = 64'h0123_4567_89AB_CDEF; start = 1'b1;
    @(negedge clk);
    chk(mask_q != 64'h0123_4567_89AB_CDEF, "R8 last-slot start ignored", mask_q, 64'd0);
    @(negedge clk);
    start = 1'b0;
    chk(mask_q == 64'h0123_4567_89AB_CDEF, "R8 start accepted when idle", mask_q, 64'h0123_4567_89AB_CDEF);

    fill(7);
    issue(3'd3, 64, 1, 32'h0000_0007); wait_idle;  // R4 R1 full masked scalar multiply
    issue(3'd2, 1, 0, '0);             wait_idle;  // R3 single element multiply

    finish_run();
  end
endmodule